// File: doc/BRIEF.md
# VRAM Slot Schedule Legality Checker

This block inspects a display-period VRAM access schedule for four scroll layers and reports, layer by layer, whether the schedule obeys the access rules. The schedule holds one 4-bit code for every (bank, time slot) pair across four VRAM banks and eight time slots. With it come, per layer, a colour depth, a reduction setting and a character size, plus a screen-mode flag that selects normal (eight slots) or high-resolution (four slots) timing.

A start pulse launches a scan that visits one bank-slot per clock, bank-major, and accumulates per-layer pattern-name and character-read counts, the slots and banks they use. When the scan is complete the block judges each layer, registers four error bits per layer, pulses `done` for one cycle and raises a sticky `valid`. Schedule and configuration inputs must stay stable from the start pulse until `done`.

Top module: `vram_slot_checker`

## Requirements
- R1: A `start` sampled high while idle begins a scan; `done` is high for exactly one cycle, 33 clock cycles after the edge that sampled `start`.
- R2: `valid` is 0 after reset, rises together with `done`, stays high afterwards, and returns to 0 in the cycle after a new scan is accepted.
- R3: A `start` pulse while a scan is running is ignored; the running scan finishes on its original timing.
- R4: Slot code for bank b, slot t sits at `sched[(b*8+t)*4 +: 4]`; bit 3 set means an access, bits 2:1 the layer, bit 0 the type (0 pattern-name, 1 character). Codes with bit 3 clear are idle and have no effect. Banks 0,1,2,3 are A0, A1, B0, B1.
- R5: Error bit 0 of a layer (count) is set when its pattern-name read count differs from 1, 2 or 4 for reduction code 0 (1x), 1 (1/2) or 2 (1/4).
- R6: The count bit is also set when the character-read count differs from the required number: depth code 0 (16 colours) 1/2/4 at 1x/half/quarter, code 1 (256) 2/4 at 1x/half, codes 2 and 3 (2048, 32768) 4 at 1x, code 4 (16.77M) 8 at 1x.
- R7: An unsupported depth/reduction pair (depth above 4, reduction code 3, or a pair absent from R6) sets error bit 3 (config) and suppresses the count and window bits of that layer.
- R8: Error bit 1 (bank) is set when a layer's pattern-name reads occur in both A0 and B0, or in both A1 and B1.
- R9: Error bit 2 (window): at 1x reduction every character read must lie in the window of each pattern-name slot of the layer; normal-mode windows for pattern-name slot T0..T7 are {0-2,4-7}, {0-3,5-7}, {0-3,6,7}, {0-3,7}, {0-3}, {1-3}, {2,3}, {3}.
- R10: In high-resolution mode (`hires`=1) slots T4-T7 are ignored; windows for T0..T3 are {0-2},{1-3},{0,2,3},{0,1,3} with 1x1 characters (`csize` bit 0) and {0-2},{1-3},{2,3},{3} with 2x2 characters (bit 1).
- R11: At 1/2 or 1/4 reduction the window bit is set when any pattern-name slot of the layer has fewer character reads inside its window than the 1x count of that depth (1 for 16, 2 for 256 colours).
- R12: When the only pattern-name slot of both layer 0 and layer 1 is T0, the window bit of these two layers is never set.
- R13: Synchronous reset clears `done`, `valid` and `err`, aborts a running scan, and `err` changes only in a cycle where `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Scan request pulse |
| hires | input | 1 | 1 = high-resolution four-slot timing |
| sched | input | 128 | Slot codes, 4 bits per bank-slot |
| depth | input | 12 | Colour depth code, 3 bits per layer |
| reduce | input | 8 | Reduction code, 2 bits per layer |
| csize | input | 4 | Character size per layer, 1 = 2x2 cells |
| done | output | 1 | One-cycle completion pulse |
| valid | output | 1 | Sticky result-valid flag |
| err | output | 16 | Per layer {config, window, bank, count}, layer L at bits 4L+3..4L |

## Verification
The bench drives boundary windows: a character read at T7 for a pattern-name at T3 must pass while T4 fails, and a design with an off-by-one window table flags the wrong one. It places pattern-name reads in A0 and B0 versus A0 and B1, which a design that grouped banks wrongly would misjudge. High-resolution runs switch character size on the same schedule and put codes in T5 and T6, catching a design that mixes the two window tables or counts ignored slots. Reduced layers get windows where one pattern-name slot is starved, the layer 0/1 T0 exemption is paired with a non-exempt twin, and a second start mid-scan and a mid-scan reset test that the done timing and sticky flags are not disturbed.

// File: rtl/vsc_pkg.sv
package vsc_pkg;
  localparam int LAYERS = 4;
  localparam int BANKS  = 4;
  localparam int SLOTS  = 8;
  localparam int CODE_W = 4;
  localparam int POS_W  = $clog2(BANKS * SLOTS);
  localparam int CNT_W  = $clog2(BANKS * SLOTS) + 1;
  localparam int PER_W  = $clog2(BANKS) + 1;
  localparam int DEP_W  = 3;
  localparam int RED_W  = 2;
  localparam int ERR_W  = 4;

  // pattern-name reads needed per reduction setting, 0 = unsupported
  function automatic logic [2:0] pn_need(input logic [RED_W-1:0] red);
    case (red)
      2'd0: return 3'd1;
      2'd1: return 3'd2;
      2'd2: return 3'd4;
      default: return 3'd0;
    endcase
  endfunction

  // character reads needed for a depth/reduction pair, 0 = unsupported
  function automatic logic [3:0] cp_need(input logic [DEP_W-1:0] dep,
                                         input logic [RED_W-1:0] red);
    logic [3:0] base;
    case (dep)
      3'd0: base = 4'd1;
      3'd1: base = 4'd2;
      3'd2, 3'd3: base = 4'd4;
      3'd4: base = 4'd8;
      default: base = 4'd0;
    endcase
    if (red == 2'd3) return 4'd0;
    if (red != 2'd0 && dep > 3'd1) return 4'd0;
    if (red == 2'd2 && dep == 3'd1) return 4'd0;
    return base << red;
  endfunction

  // allowed character slots for a pattern-name slot
  function automatic logic [SLOTS-1:0] win_mask(input logic hr, input logic big,
                                                input logic [2:0] p);
    if (!hr) begin
      case (p)
        3'd0: return 8'hF7;
        3'd1: return 8'hEF;
        3'd2: return 8'hCF;
        3'd3: return 8'h8F;
        3'd4: return 8'h0F;
        3'd5: return 8'h0E;
        3'd6: return 8'h0C;
        default: return 8'h08;
      endcase
    end
    case (p)
      3'd0: return 8'h07;
      3'd1: return 8'h0E;
      3'd2: return big ? 8'h0C : 8'h0D;
      3'd3: return big ? 8'h08 : 8'h0B;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/vsc_seq.sv
module vsc_seq
  import vsc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output logic             accept,
  output logic             busy,
  output logic [POS_W-1:0] pos,
  output logic             fin,
  output logic             done
);
  localparam logic [POS_W-1:0] LAST = POS_W'(BANKS * SLOTS - 1);

  assign accept = start && !busy && !fin;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      pos  <= '0;
      fin  <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= fin;
      fin  <= 1'b0;
      if (accept) begin
        busy <= 1'b1;
        pos  <= '0;
      end else if (busy) begin
        pos <= pos + 1'b1;
        if (pos == LAST) begin
          busy <= 1'b0;
          fin  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/vsc_layer_acc.sv
module vsc_layer_acc
  import vsc_pkg::*;
#(
  parameter int LID = 0
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   clr,
  input  logic                   step,
  input  logic [CODE_W-1:0]      code,
  input  logic [1:0]             bank,
  input  logic [2:0]             slot,
  input  logic                   hires,
  output logic [CNT_W-1:0]       pn_cnt,
  output logic [SLOTS-1:0]       pn_mask,
  output logic [BANKS-1:0]       pn_bank,
  output logic [SLOTS*3-1:0]     cp_cnt
);
  logic [2:0] cp_q [SLOTS];
  logic       hit;

  assign hit = step && code[3] && (code[2:1] == 2'(LID)) && !(hires && slot[2]);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      pn_cnt  <= '0;
      pn_mask <= '0;
      pn_bank <= '0;
      for (int t = 0; t < SLOTS; t++) cp_q[t] <= '0;
    end else if (hit) begin
      if (!code[0]) begin
        pn_cnt        <= pn_cnt + 1'b1;
        pn_mask[slot] <= 1'b1;
        pn_bank[bank] <= 1'b1;
      end else begin
        cp_q[slot] <= cp_q[slot] + 1'b1;
      end
    end
  end

  generate
    for (genvar t = 0; t < SLOTS; t++) begin : g_flat
      assign cp_cnt[t*3 +: 3] = cp_q[t];
    end
  endgenerate
endmodule

// File: rtl/vsc_layer_judge.sv
module vsc_layer_judge
  import vsc_pkg::*;
(
  input  logic [CNT_W-1:0]   pn_cnt,
  input  logic [SLOTS-1:0]   pn_mask,
  input  logic [BANKS-1:0]   pn_bank,
  input  logic [SLOTS*3-1:0] cp_cnt,
  input  logic [DEP_W-1:0]   dep,
  input  logic [RED_W-1:0]   red,
  input  logic               big,
  input  logic               hires,
  input  logic               exempt,
  output logic [ERR_W-1:0]   flags
);
  logic [2:0]       need_pn;
  logic [3:0]       need_cp, grp;
  logic [CNT_W-1:0] total, inwin;
  logic [SLOTS-1:0] w;
  logic             cfg_e, cnt_e, bank_e, win_e;

  always_comb begin
    need_pn = pn_need(red);
    need_cp = cp_need(dep, red);
    grp     = cp_need(dep, 2'd0);
    total   = '0;
    for (int t = 0; t < SLOTS; t++) total = total + CNT_W'(cp_cnt[t*3 +: 3]);
    cfg_e  = (need_cp == 4'd0) || (need_pn == 3'd0);
    cnt_e  = !cfg_e && ((pn_cnt != CNT_W'(need_pn)) || (total != CNT_W'(need_cp)));
    // A0/B0 share one group, A1/B1 the other
    bank_e = (pn_bank[0] && pn_bank[2]) || (pn_bank[1] && pn_bank[3]);
    win_e  = 1'b0;
    w      = '0;
    inwin  = '0;
    if (!cfg_e && !exempt) begin
      for (int p = 0; p < SLOTS; p++) begin
        if (pn_mask[p]) begin
          w     = win_mask(hires, big, 3'(p));
          inwin = '0;
          for (int t = 0; t < SLOTS; t++)
            if (w[t]) inwin = inwin + CNT_W'(cp_cnt[t*3 +: 3]);
          if (red == 2'd0) begin
            if (inwin != total) win_e = 1'b1;
          end else if (inwin < CNT_W'(grp)) begin
            win_e = 1'b1;
          end
        end
      end
    end
    flags = {cfg_e, win_e, bank_e, cnt_e};
  end
endmodule

// File: rtl/vram_slot_checker.sv
module vram_slot_checker
  import vsc_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        start,
  input  logic                        hires,
  input  logic [BANKS*SLOTS*CODE_W-1:0] sched,
  input  logic [LAYERS*DEP_W-1:0]     depth,
  input  logic [LAYERS*RED_W-1:0]     reduce,
  input  logic [LAYERS-1:0]           csize,
  output logic                        done,
  output logic                        valid,
  output logic [LAYERS*ERR_W-1:0]     err
);
  logic              accept, busy, fin;
  logic [POS_W-1:0]  pos;
  logic [CODE_W-1:0] cur_code;
  logic [CNT_W-1:0]   pn_cnt  [LAYERS];
  logic [SLOTS-1:0]   pn_mask [LAYERS];
  logic [BANKS-1:0]   pn_bank [LAYERS];
  logic [SLOTS*3-1:0] cp_cnt  [LAYERS];
  logic [LAYERS*ERR_W-1:0] verdict;
  logic               pair_t0;

  vsc_seq u_seq (
    .clk(clk), .rst(rst), .start(start), .accept(accept),
    .busy(busy), .pos(pos), .fin(fin), .done(done)
  );

  assign cur_code = sched[{pos, 2'b00} +: CODE_W];
  assign pair_t0  = (pn_mask[0] == SLOTS'(1)) && (pn_mask[1] == SLOTS'(1));

  generate
    for (genvar l = 0; l < LAYERS; l++) begin : g_layer
      vsc_layer_acc #(.LID(l)) u_acc (
        .clk(clk), .rst(rst), .clr(accept), .step(busy), .code(cur_code),
        .bank(pos[POS_W-1 -: 2]), .slot(pos[2:0]), .hires(hires),
        .pn_cnt(pn_cnt[l]), .pn_mask(pn_mask[l]), .pn_bank(pn_bank[l]),
        .cp_cnt(cp_cnt[l])
      );
      vsc_layer_judge u_judge (
        .pn_cnt(pn_cnt[l]), .pn_mask(pn_mask[l]), .pn_bank(pn_bank[l]),
        .cp_cnt(cp_cnt[l]), .dep(depth[l*DEP_W +: DEP_W]),
        .red(reduce[l*RED_W +: RED_W]), .big(csize[l]), .hires(hires),
        .exempt((l < 2) && pair_t0), .flags(verdict[l*ERR_W +: ERR_W])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      err   <= '0;
    end else if (fin) begin
      valid <= 1'b1;
      err   <= verdict;
    end else if (accept) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/vsc_checker.sv
module vsc_checker (
  input logic        clk,
  input logic        rst,
  input logic        start,
  input logic        busy,
  input logic        fin,
  input logic [4:0]  pos,
  input logic        done,
  input logic        valid,
  input logic [15:0] err
);
  a_r1_done_one_cycle: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r1_done_follows_fin: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(fin));
  a_r1_pos_advance: assert property (@(posedge clk) disable iff (rst)
    (busy && pos != 5'd31) |=> (busy && pos == $past(pos) + 5'd1));
  a_r3_start_ignored: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> (busy || fin));
  a_r2_valid_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(valid) |-> done);
  a_r2_valid_clear: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && !fin) |=> !valid);
  a_r13_err_hold: assert property (@(posedge clk) disable iff (rst)
    !$stable(err) |-> done);
  a_r13_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
endmodule

bind vram_slot_checker vsc_checker u_vsc_checker (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .fin(fin), .pos(pos),
  .done(done), .valid(valid), .err(err)
);

// File: tb/vram_slot_checker_test.sv
module vram_slot_checker_test;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic         hires = 1'b0;
  logic [127:0] sched = '0;
  logic [11:0]  depth = '0;
  logic [7:0]   reduce = '0;
  logic [3:0]   csize = '0;
  logic         done, valid;
  logic [15:0]  err;
  int checks = 0;
  int errs = 0;
  int lat;

  always #4 clk = ~clk;

  vram_slot_checker uut (
    .clk(clk), .rst(rst), .start(start), .hires(hires), .sched(sched),
    .depth(depth), .reduce(reduce), .csize(csize),
    .done(done), .valid(valid), .err(err)
  );

  function automatic logic [3:0] pn(input int l);
    return {1'b1, 2'(l), 1'b0};
  endfunction
  function automatic logic [3:0] cp(input int l);
    return {1'b1, 2'(l), 1'b1};
  endfunction

  task automatic put(input int b, input int s, input logic [3:0] c);
    sched[(b*8+s)*4 +: 4] = c;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // every layer 16 colours 1x, one name read and one character read
  task automatic baseline();
    sched = '0; hires = 1'b0; depth = '0; reduce = '0; csize = '0;
    for (int l = 0; l < 4; l++) begin
      put(0, l, pn(l));
      put(1, (l + 1) % 4, cp(l));
    end
  endtask

  task automatic run(input int restart_at);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    lat = 0;
    while (!done && lat < 100) begin
      @(negedge clk);
      lat++;
      if (lat == restart_at) start = 1'b1;
      else start = 1'b0;
    end
    start = 1'b0;
  endtask

  task automatic t_reset();
    chk("R13 reset done", done, 0);
    chk("R2 reset valid", valid, 0);
    chk("R13 reset err", err, 0);
  endtask

  task automatic t_legal();
    baseline();
    for (int s = 4; s < 8; s++) begin put(2, s, 4'h7); put(3, s, 4'h1); end
    run(0);
    chk("R1 latency", lat, 33);
    chk("R2 valid with done", valid, 1);
    chk("R4 legal schedule with idle codes", err, 0);
    @(negedge clk);
    chk("R1 done one cycle", done, 0);
    chk("R2 valid sticky", valid, 1);
  endtask

  task automatic t_pn_count();
    baseline();
    put(3, 5, pn(2));
    run(0);
    chk("R5 extra name read layer2", err, 16'h0100);
  endtask

  task automatic t_cp_count();
    baseline();
    depth[5:3] = 3'd1;
    run(0);
    chk("R6 256-colour short of reads", err, 16'h0010);
    put(2, 6, cp(1));
    run(0);
    chk("R6 256-colour two reads", err, 0);
  endtask

  task automatic t_config();
    baseline();
    depth[2:0] = 3'd5;
    depth[8:6] = 3'd1; reduce[5:4] = 2'd2;
    depth[11:9] = 3'd2; reduce[7:6] = 2'd1;
    run(0);
    chk("R7 unsupported pairs", err, 16'h8808);
    baseline();
    reduce[3:2] = 2'd3;
    run(0);
    chk("R7 reduction code 3", err, 16'h0080);
  endtask

  task automatic t_bank();
    baseline();
    reduce[1:0] = 2'd1;
    put(2, 4, pn(0)); put(3, 7, cp(0));
    run(0);
    chk("R8 A0 and B0 both used", err, 16'h0002);
    baseline();
    reduce[1:0] = 2'd1;
    put(3, 4, pn(0)); put(3, 7, cp(0));
    run(0);
    chk("R8 A0 and B1 allowed", err, 0);
  endtask

  task automatic t_window();
    baseline();
    put(1, 0, 4'h0); put(1, 4, cp(3));
    run(0);
    chk("R9 T3 name, T4 char outside", err, 16'h4000);
    baseline();
    put(1, 0, 4'h0); put(1, 7, cp(3));
    run(0);
    chk("R9 T3 name, T7 char inside", err, 0);
  endtask

  task automatic t_hires();
    baseline();
    hires = 1'b1;
    run(0);
    chk("R10 hires 1x1 legal", err, 0);
    csize[3] = 1'b1; csize[2] = 1'b1;
    run(0);
    chk("R10 hires 2x2 T3 window", err, 16'h4000);
    csize = '0;
    put(0, 5, pn(0)); put(1, 6, cp(3));
    run(0);
    chk("R10 slots T4-T7 ignored", err, 0);
  endtask

  task automatic t_reduced();
    baseline();
    depth[5:3] = 3'd1; reduce[3:2] = 2'd1;
    put(3, 3, pn(1)); put(2, 6, cp(1)); put(2, 0, cp(1)); put(3, 7, cp(1));
    run(0);
    chk("R11 both windows fed", err, 0);
    baseline();
    depth[5:3] = 3'd1; reduce[3:2] = 2'd1;
    put(1, 2, 4'h0); put(3, 3, pn(1));
    put(2, 5, cp(1)); put(2, 6, cp(1)); put(3, 5, cp(1)); put(3, 6, cp(1));
    run(0);
    chk("R11 T3 window starved", err, 16'h0040);
  endtask

  task automatic t_exempt();
    baseline();
    put(0, 1, 4'h0); put(2, 0, pn(1)); put(1, 1, 4'h0); put(3, 3, cp(0));
    run(0);
    chk("R12 both at T0 exempt", err, 0);
    baseline();
    put(1, 1, 4'h0); put(3, 3, cp(0));
    run(0);
    chk("R12 not exempt control", err, 16'h0004);
  endtask

  task automatic t_restart();
    baseline();
    run(10);
    chk("R3 second start ignored", lat, 33);
    @(negedge clk);
    chk("R3 no extra done", done, 0);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R2 valid cleared by start", valid, 0);
    while (!done) @(negedge clk);
  endtask

  task automatic t_abort();
    baseline();
    put(3, 5, pn(2));
    run(0);
    chk("R5 setup for reset", err, 16'h0100);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (8) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    lat = 0;
    repeat (40) begin
      @(negedge clk);
      if (done) lat++;
    end
    chk("R13 reset aborts scan", lat, 0);
    chk("R13 reset clears err", err, 0);
    chk("R2 reset clears valid", valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_legal();
    t_pn_count();
    t_cp_count();
    t_config();
    t_bank();
    t_window();
    t_hires();
    t_reduced();
    t_exempt();
    t_restart();
    t_abort();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errs++;
    $display("FAIL watchdog R1 actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule